// File: doc/BRIEF.md
# Servo pulse width digitizer

This block turns the positive pulse of a hobby radio-control servo signal into a 4-bit code. The code says how far the pulse width lies between 1 ms and 2 ms. A free-running divider turns the system clock into a 62.5 us tick, which gives 16 ticks per millisecond. With a 4.096 MHz system clock the divider ratio is 256; other clocks use another ratio. The input is synchronized and deglitched before any edge is taken from it.

Whole input pulses take turns. In a measuring pulse, the first 15 ticks of high time go into an offset counter, which marks the end of the fixed first millisecond. Every later tick while the input stays high advances a saturating code counter. The next pulse is a latch pulse. Its rising edge copies the code counter to the held output, raises a one-clock strobe, and clears both counters and the marker. The output is therefore renewed once for every two input pulses.

Top module: `servo_width_digitizer`

## Requirements
- R1: A tick occurs once every TICK_DIV system clocks. A measuring pulse whose deglitched high time spans T ticks, with 16 <= T <= 29, yields code T-15 (for example 16 ticks gives 1, 24 ticks gives 9).
- R2: The code saturates at 15. Any measuring pulse of 30 ticks or more reads 15.
- R3: A measuring pulse of 15 ticks or fewer never leaves the first millisecond and reads 0.
- R4: Input pulses alternate between measuring and latching. The first rising edge after reset starts a measuring pulse.
- R5: `code_vld` is high for exactly one clock, the clock after a latch pulse's rising edge has been detected. It never rises during a measuring pulse.
- R6: `code_o` changes only in the cycle where `code_vld` is high, and holds its value at all other times.
- R7: After a latch, the counters and the first-millisecond marker are clear, so the next measuring pulse starts from zero. For example, a 10-tick pulse that follows a saturated one reads 0.
- R8: A change of the synchronized input that lasts fewer than FILT_LEN clocks is ignored. This holds both for high spikes in the gap, which would otherwise flip the alternation, and for low dropouts inside a pulse, which would otherwise split the measurement.
- R9: Synchronous reset (`rst` high) sets `code_o` to 0 and `code_vld` to 0, clears the counters and the marker, and arms the alternation for a measuring pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pulse_in | input | 1 | Raw servo pulse, asynchronous |
| code_o | output | CODE_W | Held width code, 0 to 15 |
| code_vld | output | 1 | One-clock strobe when code_o is renewed |

## Verification
The bench makes pulses whose lengths are exact multiples of the tick period, so the tick count is known whatever the divider phase. It then sweeps the edges of the code: just under one millisecond, exactly one millisecond, the middle of the range, the last step before saturation, and well past it. If the offset were off by one, every code would shift. If saturation were missing, long pulses would wrap to small values. If the clear after a latch were missing, a short pulse after a long one would read non-zero.

Short high spikes in the gap and short low dropouts inside a pulse are injected. A filter that passed them would flip the alternation, which would give a strobe one pulse early, or split a pulse, which would give a low code. The bench also asserts reset in the middle of a pair of pulses, to catch a toggle that does not re-arm for measuring.

// File: rtl/servo_width_digitizer.sv
module servo_width_digitizer #(
  parameter int TICK_DIV     = 256,
  parameter int FILT_LEN     = 4,
  parameter int OFFSET_TICKS = 15,
  parameter int CODE_W       = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pulse_in,
  output logic [CODE_W-1:0] code_o,
  output logic              code_vld
);

  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int FLT_W = $clog2(FILT_LEN + 1);
  localparam int OFF_W = $clog2(OFFSET_TICKS + 1);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [DIV_W-1:0]  DIV_LAST = DIV_W'(TICK_DIV - 1);
  localparam logic [FLT_W-1:0]  FLT_LAST = FLT_W'(FILT_LEN - 1);
  localparam logic [OFF_W-1:0]  OFF_LAST = OFF_W'(OFFSET_TICKS - 1);

  logic [DIV_W-1:0] div_cnt;
  logic             tick;

  always_ff @(posedge clk) begin
    if (rst || div_cnt == DIV_LAST) div_cnt <= '0;
    else                            div_cnt <= div_cnt + 1'b1;
  end
  assign tick = (div_cnt == DIV_LAST);

  logic             in_meta, in_sync, filt, filt_d;
  logic [FLT_W-1:0] stab_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_meta  <= 1'b0;
      in_sync  <= 1'b0;
      filt     <= 1'b0;
      filt_d   <= 1'b0;
      stab_cnt <= '0;
    end else begin
      in_meta <= pulse_in;
      in_sync <= in_meta;
      filt_d  <= filt;
      if (in_sync == filt) begin
        stab_cnt <= '0;
      end else if (stab_cnt == FLT_LAST) begin
        filt     <= in_sync;
        stab_cnt <= '0;
      end else begin
        stab_cnt <= stab_cnt + 1'b1;
      end
    end
  end

  logic              rise, meas, clr, count_en, start;
  logic [OFF_W-1:0]  off_cnt;
  logic [CODE_W-1:0] frac;

  assign rise     = filt & ~filt_d;
  assign clr      = rise & meas;
  assign count_en = filt_d & meas & tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      meas     <= 1'b0;
      start    <= 1'b0;
      off_cnt  <= '0;
      frac     <= '0;
      code_o   <= '0;
      code_vld <= 1'b0;
    end else begin
      code_vld <= 1'b0;
      if (rise) meas <= ~meas;
      if (clr) begin
        code_o   <= frac;
        code_vld <= 1'b1;
        start    <= 1'b0;
        off_cnt  <= '0;
        frac     <= '0;
      end else if (count_en) begin
        if (!start) begin
          off_cnt <= off_cnt + 1'b1;
          if (off_cnt == OFF_LAST) start <= 1'b1;
        end else if (frac != CODE_MAX) begin
          frac <= frac + 1'b1;
        end
      end
    end
  end

  AST_FILT_NEEDS_SYNC: assert property (@(posedge clk) disable iff (rst)
    (filt != $past(filt)) |-> ($past(in_sync) == filt)); // R8
  AST_FRAC_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    !start |-> (frac == '0)); // R3
  AST_FRAC_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (frac == CODE_MAX && !clr) |=> (frac == CODE_MAX)); // R2
  AST_CLEAR_AFTER_LATCH: assert property (@(posedge clk) disable iff (rst)
    clr |=> (frac == '0 && !start && off_cnt == '0)); // R7
  AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    code_vld |=> !code_vld); // R5
  AST_VLD_ON_LATCH_EDGE: assert property (@(posedge clk) disable iff (rst)
    code_vld |-> ($past(rise) && !meas)); // R4
  AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !code_vld |-> $stable(code_o)); // R6

endmodule

// File: tb/tb_servo_width_digitizer.sv
module tb_servo_width_digitizer;
  localparam int DIV = 8;
  localparam int FL  = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin = 1'b0;
  logic [3:0] code;
  logic       vld;

  int checks = 0;
  int errors = 0;
  int vld_seen = 0;
  int cyc = 0;

  servo_width_digitizer #(.TICK_DIV(DIV), .FILT_LEN(FL), .OFFSET_TICKS(15), .CODE_W(4)) dut (
    .clk(clk), .rst(rst), .pulse_in(pin), .code_o(code), .code_vld(vld));

  always #4 clk = ~clk;

  always @(negedge clk) if (vld) vld_seen++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int n);
    @(posedge clk); #1 pin = v;
    repeat (n - 1) @(posedge clk);
  endtask

  // counting pulse of t ticks, then gap
  task automatic count_pulse(input int t, input int old_code, input string req);
    int n0;
    n0 = vld_seen;
    drive(1'b1, t * DIV);
    drive(1'b0, 40);
    @(negedge clk);
    chk({req, " R5 no strobe in measuring pulse"}, vld_seen - n0, 0);
    chk({req, " R6 code held"}, int'(code), old_code);
  endtask

  // latch pulse, expect code
  task automatic latch_pulse(input int exp, input string req);
    int n0;
    n0 = vld_seen;
    drive(1'b1, 2);
    for (int i = 0; i < 40 && vld_seen == n0; i++) @(negedge clk);
    chk({req, " code"}, int'(code), exp);
    drive(1'b1, 100);
    drive(1'b0, 40);
    @(negedge clk);
    chk({req, " R5 one strobe"}, vld_seen - n0, 1);
    chk({req, " R6 code kept"}, int'(code), exp);
  endtask

  localparam int NV = 13;
  localparam int VEC [NV][2] = '{
    '{24, 9}, '{16, 1}, '{10, 0}, '{15, 0}, '{19, 4}, '{22, 7}, '{23, 8},
    '{25, 10}, '{29, 14}, '{30, 15}, '{40, 15}, '{10, 0}, '{31, 15}};

  initial begin
    int last;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R9 reset code", int'(code), 0);
    chk("R9 reset vld", int'(vld), 0);
    #1 rst = 1'b0;
    last = 0;

    // R4 first pulse measures; R1 R2 R3 R7 sweep
    for (int i = 0; i < NV; i++) begin
      count_pulse(VEC[i][0], last, "R4");
      latch_pulse(VEC[i][1], (VEC[i][1] == 15) ? "R2" :
                             (VEC[i][0] <= 15) ? "R3 R7" : "R1");
      last = VEC[i][1];
    end

    // R8 spike in the gap must not flip the alternation
    count_pulse(20, last, "R8 spike");
    drive(1'b1, FL - 2);
    drive(1'b0, 30);
    latch_pulse(5, "R8 spike");
    last = 5;

    // R8 dropout inside a pulse must not split it
    drive(1'b1, 12 * DIV);
    drive(1'b0, FL - 2);
    drive(1'b1, 12 * DIV - (FL - 2));
    drive(1'b0, 40);
    latch_pulse(9, "R8 dropout");

    // R9 reset mid-pair re-arms measuring
    count_pulse(26, 9, "R9 pre");
    @(posedge clk); #1 rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 code after reset", int'(code), 0);
    chk("R9 vld after reset", int'(vld), 0);
    #1 rst = 1'b0;
    drive(1'b0, 20);
    count_pulse(27, 0, "R9 R4 post");
    latch_pulse(12, "R9 R4 post");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule